// File: doc/BRIEF.md
# Uncached Indexed Load/Store Unit

This block executes one indexed load or store at a time. The access bypasses every cache level. A decoded operation arrives with its direction, its access size (1, 2, 4 or 8 bytes), the number of the base register field and the values of the base, index and source registers. The unit forms the effective address and checks that the core is in hypervisor state. It also checks that the address is naturally aligned. A legal operation then issues exactly one memory request. That request is marked both cache-inhibited and guarded, and it carries byte enables. It is held on a valid/ready port until the port accepts it.

A store completes when its request is accepted. A load waits for the memory response, extracts its bytes from the addressed lanes, zero-extends them to 64 bits and presents them for writeback. Byte lanes are little-endian: lane k carries data bits 8k+7 down to 8k and corresponds to address offset k within an 8-byte word.

The control is a five-state machine:
- IDLE waits for an operation.
- REQ drives the memory request.
- WAIT awaits load data.
- DONE pulses completion.
- FAULT pulses a fault flag.

The transitions are:
- accept-legal: IDLE to REQ.
- accept-illegal: IDLE to FAULT.
- req-accepted-store: REQ to DONE.
- req-accepted-load: REQ to WAIT.
- response: WAIT to DONE.
- finish: DONE to IDLE.
- fault-retire: FAULT to IDLE.

Top module: `ucx_ldst_unit`

## Requirements
- R1: The request address equals the index value plus the base value. The base is the constant zero when `ra_field` is 0, whatever `ra_val` holds.
- R2: A store drives `mem_req_be` with N consecutive ones starting at bit `addr[2:0]`. N is 1, 2, 4 or 8 for `op_size` 0, 1, 2 or 3. It drives `mem_req_wdata` with the low N bytes of `rs_val` shifted up by 8*`addr[2:0]` bits, and zero in every disabled lane.
- R3: A load drives the same byte enables as a store of that size and address. Its `wb_data` is the N bytes of `mem_rsp_rdata` starting at lane `addr[2:0]`, with every higher bit zero.
- R4: Every request has `mem_req_nc` and `mem_req_guard` both at 1.
- R5: An operation accepted while `hyp_mode` is 0 issues no request and no `done`. It raises `fault_priv` for exactly one cycle, the cycle after acceptance. This check takes priority over the alignment check.
- R6: An operation in hypervisor state whose address is not a multiple of N issues no request and no `done`. It raises `fault_align` for exactly one cycle, the cycle after acceptance.
- R7: `mem_req_valid` rises the cycle after a legal operation is accepted. It stays high, with address, enables, data and direction unchanged, until a cycle with `mem_req_ready` high. It then drops, so exactly one transaction is made per operation.
- R8: For a store, `done` pulses for one cycle right after the request is accepted, with `wb_valid` low. For a load, `done` and `wb_valid` pulse together for one cycle right after the cycle in which `mem_rsp_valid` is high, and not before.
- R9: `op_ready` is high only when the unit is idle. An `op_valid` seen while busy is ignored and does not change the outstanding request.
- R10: After reset, `op_ready` is 1 and `mem_req_valid`, `done`, `wb_valid`, `fault_priv` and `fault_align` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken this cycle |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 0:1 byte, 1:2 bytes, 2:4 bytes, 3:8 bytes |
| ra_field | input | 5 | Base register number; 0 selects a zero base |
| ra_val | input | 64 | Base register contents |
| rb_val | input | 64 | Index register contents |
| rs_val | input | 64 | Store source register contents |
| hyp_mode | input | 1 | Core is in hypervisor state |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory port accepts request |
| mem_req_addr | output | 64 | Effective byte address |
| mem_req_write | output | 1 | 1 = write |
| mem_req_be | output | 8 | Byte lane enables |
| mem_req_wdata | output | 64 | Write data in lane position |
| mem_req_nc | output | 1 | Cache-inhibited marker |
| mem_req_guard | output | 1 | Guarded marker |
| mem_rsp_valid | input | 1 | Load response valid |
| mem_rsp_rdata | input | 64 | Load response data in lane position |
| done | output | 1 | Completion pulse |
| wb_valid | output | 1 | Load result valid for writeback |
| wb_data | output | 64 | Zero-extended load result |
| fault_priv | output | 1 | Privilege fault pulse |
| fault_align | output | 1 | Alignment fault pulse |

## Verification
The bench sweeps every size against every byte offset for both loads and stores. The sweep catches an enable mask or data shift that is off by one lane. It also catches a load that keeps garbage above the accessed bytes instead of zero-extending. A zero base field is paired with a nonzero base value, so a design that reads register contents for field 0 produces a wrong address. Misaligned and non-hypervisor operations, including a case that breaks both rules, check that no request leaks onto the bus and that the privilege fault wins. Back-pressure and late responses, with a second operation offered while busy, expose a request that drops or changes before acceptance, a duplicate transaction, and a writeback that fires before the data arrives.

// File: rtl/ucx_pkg.sv
package ucx_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } ucx_size_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_REQ   = 3'd1,
        ST_WAIT  = 3'd2,
        ST_DONE  = 3'd3,
        ST_FAULT = 3'd4
    } ucx_state_e;
endpackage

// File: rtl/ucx_agen.sv
module ucx_agen
    import ucx_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int REGNUM_W = 5,
    parameter int LANES    = 8
) (
    input  logic [REGNUM_W-1:0] ra_field,
    input  logic [ADDR_W-1:0]   ra_val,
    input  logic [ADDR_W-1:0]   rb_val,
    input  ucx_size_e           size,
    output logic [ADDR_W-1:0]   ea,
    output logic [$clog2(LANES)-1:0] off,
    output logic                misalign,
    output logic [LANES-1:0]    be
);
    localparam int OFF_W = $clog2(LANES);

    logic [ADDR_W-1:0] base;
    logic [OFF_W:0]    nbytes;
    logic [OFF_W:0]    lane_end;

    // A zero register field means a literal zero base.
    assign base     = (ra_field == '0) ? '0 : ra_val;
    assign ea       = base + rb_val;
    assign off      = ea[OFF_W-1:0];
    assign nbytes   = (OFF_W+1)'(1) << size;
    assign lane_end = {1'b0, off} + nbytes;
    assign misalign = ({1'b0, off} & (nbytes - 1'b1)) != '0;

    for (genvar i = 0; i < LANES; i++) begin : g_be
        assign be[i] = ((OFF_W+1)'(i) >= {1'b0, off}) && ((OFF_W+1)'(i) < lane_end);
    end
endmodule

// File: rtl/ucx_lanes.sv
module ucx_lanes
    import ucx_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]          st_src,
    input  logic [$clog2(DATA_W/8)-1:0] st_off,
    input  ucx_size_e                  st_size,
    output logic [DATA_W-1:0]          st_lanes,
    input  logic [DATA_W-1:0]          ld_lanes,
    input  logic [$clog2(DATA_W/8)-1:0] ld_off,
    input  ucx_size_e                  ld_size,
    output logic [DATA_W-1:0]          ld_result
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int SH_W  = OFF_W + 3;

    logic [DATA_W-1:0] st_mask;
    logic [DATA_W-1:0] ld_mask;
    logic [DATA_W-1:0] ld_shifted;
    logic [OFF_W:0]    st_n;
    logic [OFF_W:0]    ld_n;

    assign st_n = (OFF_W+1)'(1) << st_size;
    assign ld_n = (OFF_W+1)'(1) << ld_size;

    // Byte-granular masks keep only the low N bytes.
    for (genvar j = 0; j < LANES; j++) begin : g_mask
        assign st_mask[8*j +: 8] = ((OFF_W+1)'(j) < st_n) ? 8'hFF : 8'h00;
        assign ld_mask[8*j +: 8] = ((OFF_W+1)'(j) < ld_n) ? 8'hFF : 8'h00;
    end

    assign st_lanes   = (st_src & st_mask) << SH_W'({st_off, 3'b000});
    assign ld_shifted = ld_lanes >> SH_W'({ld_off, 3'b000});
    assign ld_result  = ld_shifted & ld_mask;
endmodule

// File: rtl/ucx_ldst_unit.sv
module ucx_ldst_unit
    import ucx_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 64,
    parameter int REGNUM_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic                op_store,
    input  logic [1:0]          op_size,
    input  logic [REGNUM_W-1:0] ra_field,
    input  logic [ADDR_W-1:0]   ra_val,
    input  logic [ADDR_W-1:0]   rb_val,
    input  logic [DATA_W-1:0]   rs_val,
    input  logic                hyp_mode,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic                mem_req_write,
    output logic [DATA_W/8-1:0] mem_req_be,
    output logic [DATA_W-1:0]   mem_req_wdata,
    output logic                mem_req_nc,
    output logic                mem_req_guard,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_rdata,
    output logic                done,
    output logic                wb_valid,
    output logic [DATA_W-1:0]   wb_data,
    output logic                fault_priv,
    output logic                fault_align
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    ucx_state_e state_q, state_d;

    ucx_size_e         size_in;
    logic [ADDR_W-1:0] ea;
    logic [OFF_W-1:0]  ea_off;
    logic              misalign;
    logic [LANES-1:0]  be_calc;
    logic [DATA_W-1:0] st_lanes;
    logic [DATA_W-1:0] ld_result;

    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    ucx_size_e         size_q;
    logic [OFF_W-1:0]  off_q;
    logic              priv_flt_q;
    logic [DATA_W-1:0] wb_q;

    logic accept;
    logic legal;

    assign size_in = ucx_size_e'(op_size);

    ucx_agen #(
        .ADDR_W  (ADDR_W),
        .REGNUM_W(REGNUM_W),
        .LANES   (LANES)
    ) i_agen (
        .ra_field(ra_field),
        .ra_val  (ra_val),
        .rb_val  (rb_val),
        .size    (size_in),
        .ea      (ea),
        .off     (ea_off),
        .misalign(misalign),
        .be      (be_calc)
    );

    ucx_lanes #(
        .DATA_W(DATA_W)
    ) i_lanes (
        .st_src   (rs_val),
        .st_off   (ea_off),
        .st_size  (size_in),
        .st_lanes (st_lanes),
        .ld_lanes (mem_rsp_rdata),
        .ld_off   (off_q),
        .ld_size  (size_q),
        .ld_result(ld_result)
    );

    assign accept = (state_q == ST_IDLE) && op_valid;
    assign legal  = hyp_mode && !misalign;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (op_valid) state_d = legal ? ST_REQ : ST_FAULT;
            ST_REQ:   if (mem_req_ready) state_d = write_q ? ST_DONE : ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and captured operation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            addr_q     <= '0;
            be_q       <= '0;
            wdata_q    <= '0;
            write_q    <= 1'b0;
            size_q     <= SZ_BYTE;
            off_q      <= '0;
            priv_flt_q <= 1'b0;
            wb_q       <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q     <= ea;
                be_q       <= be_calc;
                wdata_q    <= op_store ? st_lanes : '0;
                write_q    <= op_store;
                size_q     <= size_in;
                off_q      <= ea_off;
                priv_flt_q <= !hyp_mode;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                wb_q <= ld_result;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        op_ready      = 1'b0;
        mem_req_valid = 1'b0;
        done          = 1'b0;
        wb_valid      = 1'b0;
        fault_priv    = 1'b0;
        fault_align   = 1'b0;
        unique case (state_q)
            ST_IDLE:  op_ready = 1'b1;
            ST_REQ:   mem_req_valid = 1'b1;
            ST_WAIT:  ;
            ST_DONE: begin
                done     = 1'b1;
                wb_valid = !write_q;
            end
            ST_FAULT: begin
                fault_priv  = priv_flt_q;
                fault_align = !priv_flt_q;
            end
            default:  ;
        endcase
    end

    assign mem_req_addr  = addr_q;
    assign mem_req_write = write_q;
    assign mem_req_be    = be_q;
    assign mem_req_wdata = wdata_q;
    assign mem_req_nc    = mem_req_valid;
    assign mem_req_guard = mem_req_valid;
    assign wb_data       = wb_valid ? wb_q : '0;
endmodule

// File: rtl/ucx_ldst_chk.sv
module ucx_ldst_chk #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 64
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_ready,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic [ADDR_W-1:0]   mem_req_addr,
    input logic                mem_req_write,
    input logic [DATA_W/8-1:0] mem_req_be,
    input logic [DATA_W-1:0]   mem_req_wdata,
    input logic                mem_req_nc,
    input logic                mem_req_guard,
    input logic                done,
    input logic                wb_valid,
    input logic                fault_priv,
    input logic                fault_align
);
    p_attrs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_nc && mem_req_guard));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_be) && $stable(mem_req_wdata) && $stable(mem_req_write)));

    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    p_be_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_be != '0));

    p_wb_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> done);

    p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_priv || fault_align) |-> (!done && !mem_req_valid));

    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_priv, fault_align}));

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || done) |-> !op_ready);
endmodule

bind ucx_ldst_unit ucx_ldst_chk #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) i_ucx_ldst_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_ready     (op_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .mem_req_write(mem_req_write),
    .mem_req_be   (mem_req_be),
    .mem_req_wdata(mem_req_wdata),
    .mem_req_nc   (mem_req_nc),
    .mem_req_guard(mem_req_guard),
    .done         (done),
    .wb_valid     (wb_valid),
    .fault_priv   (fault_priv),
    .fault_align  (fault_align)
);

// File: tb/test_ucx_ldst_unit.sv
`timescale 1ns/1ps
module test_ucx_ldst_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_store = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic [4:0]  ra_field = 5'd0;
    logic [63:0] ra_val = '0;
    logic [63:0] rb_val = '0;
    logic [63:0] rs_val = '0;
    logic        hyp_mode = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_req_write;
    logic [7:0]  mem_req_be;
    logic [63:0] mem_req_wdata;
    logic        mem_req_nc;
    logic        mem_req_guard;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_rdata = '0;
    logic        done;
    logic        wb_valid;
    logic [63:0] wb_data;
    logic        fault_priv;
    logic        fault_align;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ucx_ldst_unit i_ucx_ldst_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input int sz, input logic [4:0] raf,
                          input logic [63:0] ra, input logic [63:0] rb,
                          input logic [63:0] rs, input bit hyp, input int rdy_dly,
                          input int rsp_dly, input logic [63:0] rdata, input bit poke);
        logic [63:0] ea;
        logic [63:0] mask;
        logic [15:0] be16;
        logic [63:0] exp_w;
        logic [63:0] exp_r;
        int n;
        int off;
        bit aligned;
        ea      = ((raf == 5'd0) ? 64'd0 : ra) + rb;
        n       = 1 << sz;
        off     = int'(ea[2:0]);
        aligned = (ea % n) == 0;
        mask    = (n == 8) ? '1 : ((64'd1 << (8 * n)) - 64'd1);
        be16    = 16'(((1 << n) - 1) << off);
        exp_w   = (rs & mask) << (8 * off);
        exp_r   = (rdata >> (8 * off)) & mask;

        @(negedge clk);
        chk(op_ready == 1'b1, "R9 idle ready", 64'(op_ready), 64'd1);
        op_valid = 1'b1; op_store = st; op_size = 2'(sz); ra_field = raf;
        ra_val = ra; rb_val = rb; rs_val = rs; hyp_mode = hyp;
        @(negedge clk);
        op_valid = 1'b0;
        if (!hyp || !aligned) begin
            chk(mem_req_valid == 1'b0 && done == 1'b0, hyp ? "R6 no request" : "R5 no request",
                64'({mem_req_valid, done}), 64'd0);
            if (!hyp)
                chk(fault_priv == 1'b1 && fault_align == 1'b0, "R5 priv fault",
                    64'({fault_priv, fault_align}), 64'b10);
            else
                chk(fault_align == 1'b1 && fault_priv == 1'b0, "R6 align fault",
                    64'({fault_priv, fault_align}), 64'b01);
            @(negedge clk);
            chk(fault_priv == 1'b0 && fault_align == 1'b0 && mem_req_valid == 1'b0,
                "R5 R6 fault single pulse", 64'({fault_priv, fault_align, mem_req_valid}), 64'd0);
            return;
        end
        chk(mem_req_valid == 1'b1, "R7 request raised", 64'(mem_req_valid), 64'd1);
        chk(mem_req_addr == ea, "R1 address", mem_req_addr, ea);
        chk(mem_req_nc == 1'b1 && mem_req_guard == 1'b1, "R4 nc guard",
            64'({mem_req_nc, mem_req_guard}), 64'b11);
        chk(mem_req_be == be16[7:0], st ? "R2 store be" : "R3 load be",
            64'(mem_req_be), 64'(be16[7:0]));
        chk(mem_req_write == st, "R7 direction", 64'(mem_req_write), 64'(st));
        if (st) chk(mem_req_wdata == exp_w, "R2 store data", mem_req_wdata, exp_w);
        for (int k = 0; k < rdy_dly; k++) begin
            if (poke) begin
                op_valid = 1'b1; rb_val = rb + 64'h40; op_store = ~st;
            end
            @(negedge clk);
            chk(mem_req_valid == 1'b1 && mem_req_addr == ea && op_ready == 1'b0,
                "R7 R9 request held", mem_req_addr, ea);
            chk(mem_req_be == be16[7:0], "R7 be held", 64'(mem_req_be), 64'(be16[7:0]));
        end
        op_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk(mem_req_valid == 1'b0, "R7 single transaction", 64'(mem_req_valid), 64'd0);
        if (st) begin
            chk(done == 1'b1 && wb_valid == 1'b0, "R8 store done",
                64'({done, wb_valid}), 64'b10);
        end else begin
            chk(done == 1'b0, "R8 load waits", 64'(done), 64'd0);
            for (int k = 0; k < rsp_dly; k++) begin
                @(negedge clk);
                chk(done == 1'b0 && wb_valid == 1'b0 && mem_req_valid == 1'b0,
                    "R8 no early writeback", 64'({done, wb_valid}), 64'd0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_rdata = rdata;
            @(negedge clk);
            mem_rsp_valid = 1'b0; mem_rsp_rdata = ~rdata;
            chk(done == 1'b1 && wb_valid == 1'b1, "R8 load done", 64'({done, wb_valid}), 64'b11);
            chk(wb_data == exp_r, "R3 load result", wb_data, exp_r);
        end
        @(negedge clk);
        chk(done == 1'b0 && op_ready == 1'b1 && mem_req_valid == 1'b0, "R8 R9 back to idle",
            64'({done, op_ready, mem_req_valid}), 64'b010);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(op_ready == 1'b1 && mem_req_valid == 1'b0 && done == 1'b0 && wb_valid == 1'b0
            && fault_priv == 1'b0 && fault_align == 1'b0, "R10 reset state",
            64'({op_ready, mem_req_valid, done, wb_valid, fault_priv, fault_align}), 64'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(op_ready == 1'b1 && mem_req_valid == 1'b0, "R10 after reset",
            64'({op_ready, mem_req_valid}), 64'b10);

        // Sweep sizes, offsets and directions in hypervisor state.
        for (int st = 0; st < 2; st++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int off = 0; off < 8; off++) begin
                    logic [4:0]  raf;
                    logic [63:0] ra;
                    raf = ((off % 2) == 0) ? 5'd0 : 5'(off + sz + 1);
                    ra  = 64'h1000_0000_0000_0000 + 64'(sz * 64'h100);
                    run_op(st[0], sz, raf, ra, 64'h0000_0000_0000_2000 + 64'(off),
                           64'hF1E2_D3C4_B5A6_9788 ^ 64'(off * 17 + sz),
                           1'b1, off % 3, (off + sz) % 3,
                           64'h8877_6655_4433_2211 + 64'(st * 3 + off), (off == 2));
                end
            end
        end

        // Privilege fault, also when misaligned, and with a zero base field.
        run_op(1'b1, 3, 5'd0, 64'hDEAD, 64'h3000, '1, 1'b0, 0, 0, '0, 1'b0);
        run_op(1'b0, 2, 5'd7, 64'h10, 64'h3, '0, 1'b0, 0, 0, '0, 1'b0);
        run_op(1'b0, 0, 5'd3, 64'h10, 64'h5, '0, 1'b0, 0, 0, '0, 1'b0);

        // Address wrap-around with a nonzero base, loads of every size.
        for (int sz = 0; sz < 4; sz++) begin
            run_op(1'b0, sz, 5'd31, 64'hFFFF_FFFF_FFFF_FFF8, 64'h10, '0, 1'b1, 1, 2,
                   64'hFEDC_BA98_7654_3210, 1'b0);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule